// File: doc/BRIEF.md
# Serial Port Host Register Block

This block is the host-facing register file of an asynchronous serial port. A CPU reads and writes byte-wide registers through a simple select/write bus. The registers are a control register, a status register, a transmit data register, a receive data register and a tick-delay register. Bit shifting, baud generation and line sampling happen elsewhere. This block exchanges only whole bytes with a transmit port and a receive port, and it raises two interrupt requests.

The status register has five hardware flags. Software clears a flag by writing 0 to its bit. Writing 1 to a flag bit leaves the flag as it is. After each write to transmit data, the transmit-empty flag does not return at once. It comes back once a programmable number of `tick` pulses has elapsed. The expected host sequence is:

1. Wait for transmit-empty.
2. Write the byte.
3. Clear transmit-empty with a status write.

The transmit port has no back-pressure. A byte is presented on `tx_valid`/`tx_data` for exactly one cycle, and the transmit-empty flag is the only flow control. The receive port is valid/ready:

- `rx_ready` mirrors the receive-enable bit, and a byte is taken on any cycle where `rx_valid` and `rx_ready` are both high.
- A byte offered while `rx_ready` is low is dropped.
- The sender must not hold a byte waiting for `rx_ready`.

Top module: `sport_regif`

## Requirements
- R1: After reset:
  - control reads 0x00.
  - status reads 0x80, with only transmit-empty set.
  - the delay register reads 2.
  - `tx_valid`, `irq_tx`, `irq_rx` and `rx_ready` are 0.
- R2: The register offsets are:
  - 0 is control.
  - 1 is status.
  - 2 is transmit data, which reads back the last byte written.
  - 3 is receive data.
  - 4 is the tick delay.

  Control stores all eight written bits and reads them back. Its bits are 7 transmit-IRQ enable, 6 receive-IRQ enable, 5 transmit enable and 4 receive enable, and `rx_ready` equals bit 4.
- R3: Status bits are 7 transmit-empty, 6 receive-full, 5 overrun, 4 framing error and 3 parity error. A status write with value v leaves status equal to `(old & v & 0xF8) | (v & 0x07)`. A 0 clears a flag, a 1 never sets one, and bits 2..0 take the written value.
- R4: A write to transmit data while control bit 5 is set makes `tx_valid` high for exactly the following cycle, with `tx_data` equal to the byte. With bit 5 clear, no strobe is produced.
- R5: After a transmit-data write, transmit-empty is set on the max(1, D)-th `tick` pulse, where D is the delay register value at the time of the write. It is not set earlier. Ticks with no write pending never set it.
- R6: The delay register is writable and reads back. A new transmit-data write while the countdown is pending restarts the countdown from D.
- R7: When a byte is accepted and receive-full is clear:
  - receive data takes the byte.
  - receive-full is set.
  - framing error and parity error are set if `rx_ferr` or `rx_perr` accompany the byte.
- R8: When a byte is accepted while receive-full is set, overrun is set and receive data keeps its old value.
- R9: A byte offered while receive enable is clear changes no register. A host write to the receive-data offset also changes no register.
- R10: The interrupt outputs are:
  - `irq_tx` = control bit 7 AND transmit-empty.
  - `irq_rx` = control bit 6 AND (receive-full OR overrun OR framing OR parity).
- R11: When the countdown sets transmit-empty in the same cycle as a status write that clears it, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 1 | Host access select |
| host_wr | input | 1 | Host write when selected |
| host_addr | input | ADDR_W (3) | Register offset |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr`; combinational |
| tick | input | 1 | Countdown tick pulse |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive byte will be taken (receive enable) |
| rx_data | input | 8 | Received byte |
| rx_ferr | input | 1 | Framing error with this byte |
| rx_perr | input | 1 | Parity error with this byte |
| tx_valid | output | 1 | One-cycle transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |

## Verification
The bench covers all 256 status write values twice: once with every flag latched and once with every flag clear. This exposes a design that lets a written 1 set a flag, or that lets a written 0 leak into the plain bits. It sweeps the tick delay from 0 to 6 and counts ticks until transmit-empty returns. An off-by-one countdown, or a delay of 0 that never fires, shows up as a wrong tick count. Further cases target specific mistakes:

- A mid-countdown rewrite catches a design that fails to reload the counter.
- A same-cycle clear and countdown completion catches a design in which software wins.
- Overrun and disabled-receive cases catch a receive register that is overwritten when it must be held.

// File: rtl/sport_pkg.sv
package sport_pkg;
  localparam int OFS_CTRL = 0;
  localparam int OFS_STAT = 1;
  localparam int OFS_TXD  = 2;
  localparam int OFS_RXD  = 3;
  localparam int OFS_DLY  = 4;

  localparam int CTL_TXIE = 7;
  localparam int CTL_RXIE = 6;
  localparam int CTL_TXEN = 5;
  localparam int CTL_RXEN = 4;

  localparam int ST_TXE  = 7;
  localparam int ST_RXF  = 6;
  localparam int ST_OVR  = 5;
  localparam int ST_FRM  = 4;
  localparam int ST_PAR  = 3;

  localparam logic [7:0] FLAG_MASK = 8'hF8;
  localparam logic [7:0] STAT_RST  = 8'h80;

  typedef struct packed {
    logic ctrl;
    logic stat;
    logic txd;
    logic dly;
  } reg_wr_t;

  typedef struct packed {
    logic txe;
    logic rxf;
    logic ovr;
    logic frm;
    logic par;
  } flag_set_t;
endpackage

// File: rtl/sport_decode.sv
module sport_decode
  import sport_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8
) (
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  output reg_wr_t           wr,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] stat_q,
  input  logic [DATA_W-1:0] txd_q,
  input  logic [DATA_W-1:0] rxd_q,
  input  logic [CNT_W-1:0]  dly_q,
  output logic [DATA_W-1:0] rdata
);
  logic              wr_en;
  logic [DATA_W-1:0] dly_ext;

  assign wr_en = host_sel & host_wr;

  generate
    if (CNT_W < DATA_W) begin : g_pad
      assign dly_ext = {{(DATA_W-CNT_W){1'b0}}, dly_q};
    end else begin : g_full
      assign dly_ext = dly_q[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    wr.ctrl = wr_en && (host_addr == ADDR_W'(OFS_CTRL));
    wr.stat = wr_en && (host_addr == ADDR_W'(OFS_STAT));
    wr.txd  = wr_en && (host_addr == ADDR_W'(OFS_TXD));
    wr.dly  = wr_en && (host_addr == ADDR_W'(OFS_DLY));
  end

  always_comb begin
    rdata = '0;
    if (host_addr == ADDR_W'(OFS_CTRL))      rdata = ctrl_q;
    else if (host_addr == ADDR_W'(OFS_STAT)) rdata = stat_q;
    else if (host_addr == ADDR_W'(OFS_TXD))  rdata = txd_q;
    else if (host_addr == ADDR_W'(OFS_RXD))  rdata = rxd_q;
    else if (host_addr == ADDR_W'(OFS_DLY))  rdata = dly_ext;
  end
endmodule

// File: rtl/sport_txtimer.sv
module sport_txtimer #(
  parameter int               CNT_W   = 8,
  parameter logic [CNT_W-1:0] DLY_RST = CNT_W'(2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dly_we,
  input  logic [CNT_W-1:0] dly_wdata,
  input  logic             arm,
  input  logic             tick,
  output logic [CNT_W-1:0] dly_q,
  output logic             set_txe
);
  logic             pend_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last;

  assign last    = (cnt_q <= CNT_W'(1));
  assign set_txe = tick & pend_q & ~arm & last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dly_q <= DLY_RST;
    end else if (dly_we) begin
      dly_q <= dly_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (arm) begin
      pend_q <= 1'b1;
      cnt_q  <= dly_q;
    end else if (tick && pend_q) begin
      if (last) begin
        pend_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sport_rxpath.sv
module sport_rxpath
  import sport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ferr,
  input  logic              rx_perr,
  input  logic              rxf_q,
  output logic              set_rxf,
  output logic              set_ovr,
  output logic              set_frm,
  output logic              set_par,
  output logic [DATA_W-1:0] rxd_q
);
  logic take;
  logic load;

  assign take    = rx_valid & rx_en;
  assign load    = take & ~rxf_q;
  assign set_rxf = load;
  assign set_ovr = take & rxf_q;
  assign set_frm = load & rx_ferr;
  assign set_par = load & rx_perr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxd_q <= '0;
    end else if (load) begin
      rxd_q <= rx_data;
    end
  end
endmodule

// File: rtl/sport_status.sv
module sport_status
  import sport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stat,
  input  logic [DATA_W-1:0] wdata,
  input  flag_set_t         hw_set,
  output logic [DATA_W-1:0] stat_q
);
  localparam logic [DATA_W-1:0] FMASK = DATA_W'(FLAG_MASK);

  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = stat_q;
    if (wr_stat) begin
      nxt = (stat_q & wdata & FMASK) | (wdata & ~FMASK);
    end
    if (hw_set.txe) nxt[ST_TXE] = 1'b1;
    if (hw_set.rxf) nxt[ST_RXF] = 1'b1;
    if (hw_set.ovr) nxt[ST_OVR] = 1'b1;
    if (hw_set.frm) nxt[ST_FRM] = 1'b1;
    if (hw_set.par) nxt[ST_PAR] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= DATA_W'(STAT_RST);
    end else begin
      stat_q <= nxt;
    end
  end
endmodule

// File: rtl/sport_regif.sv
module sport_regif
  import sport_pkg::*;
#(
  parameter int ADDR_W  = 3,
  parameter int DATA_W  = 8,
  parameter int CNT_W   = 8,
  parameter int DLY_RST = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_sel,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              tick,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic              rx_ferr,
  input  logic              rx_perr,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  output logic              irq_tx,
  output logic              irq_rx
);
  reg_wr_t           wr;
  flag_set_t         hw_set;
  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] stat_q;
  logic [DATA_W-1:0] txd_q;
  logic [DATA_W-1:0] rxd_q;
  logic [CNT_W-1:0]  dly_q;
  logic              tx_valid_q;
  logic [DATA_W-1:0] tx_data_q;

  sport_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_dec (
    .host_sel (host_sel),
    .host_wr  (host_wr),
    .host_addr(host_addr),
    .wr       (wr),
    .ctrl_q   (ctrl_q),
    .stat_q   (stat_q),
    .txd_q    (txd_q),
    .rxd_q    (rxd_q),
    .dly_q    (dly_q),
    .rdata    (host_rdata)
  );

  sport_txtimer #(.CNT_W(CNT_W), .DLY_RST(CNT_W'(DLY_RST))) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .dly_we   (wr.dly),
    .dly_wdata(host_wdata[CNT_W-1:0]),
    .arm      (wr.txd),
    .tick     (tick),
    .dly_q    (dly_q),
    .set_txe  (hw_set.txe)
  );

  sport_rxpath #(.DATA_W(DATA_W)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_en   (ctrl_q[CTL_RXEN]),
    .rx_valid(rx_valid),
    .rx_data (rx_data),
    .rx_ferr (rx_ferr),
    .rx_perr (rx_perr),
    .rxf_q   (stat_q[ST_RXF]),
    .set_rxf (hw_set.rxf),
    .set_ovr (hw_set.ovr),
    .set_frm (hw_set.frm),
    .set_par (hw_set.par),
    .rxd_q   (rxd_q)
  );

  sport_status #(.DATA_W(DATA_W)) u_st (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stat(wr.stat),
    .wdata  (host_wdata),
    .hw_set (hw_set),
    .stat_q (stat_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      txd_q  <= '0;
    end else begin
      if (wr.ctrl) ctrl_q <= host_wdata;
      if (wr.txd)  txd_q  <= host_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_valid_q <= 1'b0;
      tx_data_q  <= '0;
    end else begin
      tx_valid_q <= wr.txd & ctrl_q[CTL_TXEN];
      if (wr.txd) tx_data_q <= host_wdata;
    end
  end

  assign tx_valid = tx_valid_q;
  assign tx_data  = tx_data_q;
  assign rx_ready = ctrl_q[CTL_RXEN];
  assign irq_tx   = ctrl_q[CTL_TXIE] & stat_q[ST_TXE];
  assign irq_rx   = ctrl_q[CTL_RXIE] &
                    (stat_q[ST_RXF] | stat_q[ST_OVR] | stat_q[ST_FRM] | stat_q[ST_PAR]);
endmodule

// File: rtl/sport_regif_chk.sv
module sport_regif_chk
  import sport_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_sel,
  input logic              host_wr,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic              tick,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [DATA_W-1:0] rx_data,
  input logic              tx_valid,
  input logic              irq_tx,
  input logic [DATA_W-1:0] stat_q,
  input logic [DATA_W-1:0] rxd_q
);
  logic host_w;
  logic take;
  assign host_w = host_sel & host_wr;
  assign take   = rx_valid & rx_ready;

  assert_tx_strobe_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(host_w && host_addr == ADDR_W'(OFS_TXD)));

  assert_txe_rise_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[ST_TXE]) |-> $past(tick));

  assert_one_never_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (host_w && host_addr == ADDR_W'(OFS_STAT) && host_wdata[ST_RXF] &&
     !stat_q[ST_RXF] && !take) |=> !stat_q[ST_RXF]);

  assert_rx_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !stat_q[ST_RXF]) |=> (stat_q[ST_RXF] && rxd_q == $past(rx_data)));

  assert_overrun_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && stat_q[ST_RXF]) |=> (stat_q[ST_OVR] && $stable(rxd_q)));

  assert_rx_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> $stable(rxd_q));

  assert_irq_tx_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_tx) |-> $past(tick || host_w));
endmodule

bind sport_regif sport_regif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .host_sel  (host_sel),
  .host_wr   (host_wr),
  .host_addr (host_addr),
  .host_wdata(host_wdata),
  .tick      (tick),
  .rx_valid  (rx_valid),
  .rx_ready  (rx_ready),
  .rx_data   (rx_data),
  .tx_valid  (tx_valid),
  .irq_tx    (irq_tx),
  .stat_q    (stat_q),
  .rxd_q     (rxd_q)
);

// File: tb/sport_regif_tb.sv
module sport_regif_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_sel = 1'b0;
  logic       host_wr = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       tick = 1'b0;
  logic       rx_valid = 1'b0;
  logic       rx_ready;
  logic [7:0] rx_data = '0;
  logic       rx_ferr = 1'b0;
  logic       rx_perr = 1'b0;
  logic       tx_valid;
  logic [7:0] tx_data;
  logic       irq_tx;
  logic       irq_rx;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  sport_regif dut_i (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tick(tick), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .rx_ferr(rx_ferr), .rx_perr(rx_perr), .tx_valid(tx_valid), .tx_data(tx_data),
    .irq_tx(irq_tx), .irq_rx(irq_rx)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic do_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic do_rd(input logic [2:0] a, output logic [7:0] d);
    host_addr = a;
    #1;
    d = host_rdata;
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_rx(input logic [7:0] d, input logic fe, input logic pe);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d; rx_ferr = fe; rx_perr = pe;
    @(negedge clk);
    rx_valid = 1'b0; rx_ferr = 1'b0; rx_perr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    int need;

    do_reset();
    // R1 reset state
    do_rd(3'd0, r); chk("R1 ctrl", r, 8'h00);
    do_rd(3'd1, r); chk("R1 status", r, 8'h80);
    do_rd(3'd4, r); chk("R1 delay", r, 2);
    chk("R1 tx_valid", tx_valid, 0);
    chk("R1 irq_tx", irq_tx, 0);
    chk("R1 irq_rx", irq_rx, 0);
    chk("R1 rx_ready", rx_ready, 0);

    // R2 / R10: control sweep with transmit-empty set, no receive flags
    for (int v = 0; v < 256; v++) begin
      do_wr(3'd0, 8'(v));
      do_rd(3'd0, r); chk("R2 ctrl readback", r, v);
      chk("R2 rx_ready", rx_ready, (v >> 4) & 1);
      chk("R10 irq_tx", irq_tx, (v >> 7) & 1);
      chk("R10 irq_rx", irq_rx, 0);
    end

    // R3 / R8: every status write with all flags latched
    for (int v = 0; v < 256; v++) begin
      do_reset();
      do_wr(3'd0, 8'h10);
      do_rx(8'h11, 1'b1, 1'b1);
      do_rx(8'h22, 1'b0, 1'b0);
      if (v == 0) begin
        do_rd(3'd3, r); chk("R8 rx data held", r, 8'h11);
        do_rd(3'd1, r); chk("R8 overrun set", r, 8'hF8);
      end
      do_wr(3'd1, 8'(v));
      do_rd(3'd1, r); chk("R3 flags set", r, (8'hF8 & v) | (v & 8'h07));
    end

    // R3: every status write with all flags clear
    do_reset();
    do_wr(3'd1, 8'h00);
    do_rd(3'd1, r); chk("R3 clear all", r, 8'h00);
    for (int v = 0; v < 256; v++) begin
      do_wr(3'd1, 8'(v));
      do_rd(3'd1, r); chk("R3 flags clear", r, v & 8'h07);
    end

    // R4 transmit strobe
    do_reset();
    do_wr(3'd2, 8'h5A);
    chk("R4 no strobe without enable", tx_valid, 0);
    do_wr(3'd0, 8'h20);
    do_wr(3'd2, 8'hA5);
    chk("R4 strobe", tx_valid, 1);
    chk("R4 strobe data", tx_data, 8'hA5);
    @(negedge clk);
    chk("R4 strobe one cycle", tx_valid, 0);
    do_rd(3'd2, r); chk("R2 txd readback", r, 8'hA5);

    // R5 / R6 countdown sweep over delay values
    for (int d = 0; d <= 6; d++) begin
      do_reset();
      do_wr(3'd1, 8'h78);
      repeat (3) do_tick();
      do_rd(3'd1, r); chk("R5 idle ticks", r[7], 0);
      do_wr(3'd4, 8'(d));
      do_rd(3'd4, r); chk("R6 delay readback", r, d);
      do_wr(3'd2, 8'h33);
      do_rd(3'd1, r); chk("R5 pending", r[7], 0);
      need = (d < 1) ? 1 : d;
      for (int k = 1; k <= 8; k++) begin
        do_tick();
        do_rd(3'd1, r);
        chk($sformatf("R5 d=%0d tick=%0d", d, k), r[7], (k >= need) ? 1 : 0);
      end
    end

    // R6 reload while pending
    do_reset();
    do_wr(3'd4, 8'd3);
    do_wr(3'd1, 8'h78);
    do_wr(3'd2, 8'h01);
    repeat (2) do_tick();
    do_wr(3'd2, 8'h02);
    repeat (2) do_tick();
    do_rd(3'd1, r); chk("R6 reload not yet", r[7], 0);
    do_tick();
    do_rd(3'd1, r); chk("R6 reload done", r[7], 1);

    // R11 hardware set wins over clearing write
    do_reset();
    do_wr(3'd4, 8'd1);
    do_wr(3'd1, 8'h78);
    do_wr(3'd2, 8'h44);
    @(negedge clk);
    tick = 1'b1; host_sel = 1'b1; host_wr = 1'b1; host_addr = 3'd1; host_wdata = 8'h00;
    @(negedge clk);
    tick = 1'b0; host_sel = 1'b0; host_wr = 1'b0;
    do_rd(3'd1, r); chk("R11 set wins", r, 8'h80);

    // R7 / R10 receive path
    do_reset();
    do_wr(3'd0, 8'h10);
    do_rx(8'h3C, 1'b0, 1'b0);
    do_rd(3'd3, r); chk("R7 rx data", r, 8'h3C);
    do_rd(3'd1, r); chk("R7 rx full", r, 8'hC0);
    chk("R10 irq_rx disabled", irq_rx, 0);
    do_wr(3'd0, 8'h50);
    chk("R10 irq_rx on full", irq_rx, 1);
    do_wr(3'd1, 8'hB8);
    do_rd(3'd1, r); chk("R3 rx full cleared", r, 8'h80);
    chk("R10 irq_rx off", irq_rx, 0);
    do_rx(8'h4B, 1'b1, 1'b0);
    do_rd(3'd3, r); chk("R7 rx data ferr", r, 8'h4B);
    do_rd(3'd1, r); chk("R7 framing flag", r, 8'hD0);

    // R9 ignored receive and write to receive offset
    do_wr(3'd0, 8'h00);
    do_wr(3'd1, 8'hB8);
    do_rx(8'h77, 1'b1, 1'b1);
    do_rd(3'd3, r); chk("R9 rx disabled data", r, 8'h4B);
    do_rd(3'd1, r); chk("R9 rx disabled status", r, 8'h90);
    do_wr(3'd3, 8'hEE);
    do_rd(3'd3, r); chk("R9 host write to rx data", r, 8'h4B);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule